// File: doc/BRIEF.md
# Open-Row-First Memory Request Selector

This block chooses which pending memory request a controller should serve next. It looks at a fixed-depth queue whose slot 0 is the oldest. Each occupied slot names a rank, a bank within that rank, and a row. For every bank, the block also sees three things: whether a row is open and which one, the earliest cycle at which the bank may be activated, and the earliest cycle at which it may be precharged. It also sees the present cycle count. From these inputs it computes a registered choice: the slot to serve, a class code that says why that slot won, and a mask of the banks that could open a row soonest.

The class code is held in a small state register. It takes one of four states:

- IDLE (code 0): the queue is empty.
- OPEN_HIT (code 1): an entry targets its bank's open row.
- BANK_READY (code 2): the chosen miss can be activated now.
- SOONEST (code 3): the chosen miss belongs to one of the banks with the lowest activation estimate.

The next state is recomputed on every clock edge from the sampled inputs. Any state can move to any other state at any edge, depending only on those inputs. Reset forces IDLE.

Queue storage, command issue and bank timing updates belong to neighbouring blocks.

Top module: `dram_row_picker`

## Requirements
- R1: While reset is asserted and on the first sample after it, the class code is 0 (IDLE), the valid flag is 0, the index is 0 and the soonest-bank mask is 0.
- R2: Slots with their valid bit clear play no part in any rule or in the mask. When no slot is valid, the next output is valid 0, class 0, index 0 and mask 0.
- R3: If any valid slot names a bank whose open row equals the slot's row, the lowest-numbered such slot is chosen with class 1, even when older misses exist.
- R4: Each bank's activation estimate depends on whether it has an open row. A closed bank uses its activate-allowed time. A bank with an open row uses the larger of its precharge-allowed time and the present cycle, plus the parameter T_RP; its activate-allowed time is then ignored.
- R5: With no open-row match, the lowest-numbered valid slot is chosen if its bank's estimate is at or before the present cycle (class 2, inclusive), or if its bank's bit is set in the soonest-bank mask (class 3 when the estimate is still in the future).
- R6: The soonest-bank mask sets bit b for every bank b that has at least one valid slot and whose estimate equals the minimum estimate over such banks. Ties set several bits.
- R7: A slot's flat bank number is rank × BANKS_PER_RANK + bank. Per-bank inputs, and mask bit positions, are indexed by that number. At most 64 banks are supported.
- R8: Outputs change only on a rising clock edge. They reflect the inputs sampled at that edge and stay unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_vld | input | DEPTH | Per-slot occupied bit, slot 0 oldest |
| ent_rank | input | DEPTH*RANK_W | Rank of each slot, slot i at bits i*RANK_W |
| ent_bank | input | DEPTH*BANK_W | Bank within rank of each slot |
| ent_row | input | DEPTH*ROW_W | Row of each slot |
| bank_open | input | NUM_BANKS | Per flat bank: a row is open |
| bank_row | input | NUM_BANKS*ROW_W | Per flat bank: the open row |
| bank_act_ok | input | NUM_BANKS*TIME_W | Per flat bank: earliest activate cycle |
| bank_pre_ok | input | NUM_BANKS*TIME_W | Per flat bank: earliest precharge cycle |
| now | input | TIME_W | Present cycle count |
| pick_valid | output | 1 | A slot is chosen |
| pick_idx | output | IDX_W | Chosen slot |
| pick_kind | output | 2 | Class code: 0 IDLE, 1 OPEN_HIT, 2 BANK_READY, 3 SOONEST |
| early_mask | output | NUM_BANKS | Banks with the lowest activation estimate among banks with waiting slots |

## Verification
On every cycle, the embedded properties check several relations. A chosen slot is always valid. An empty queue yields IDLE. An open-row match always wins, and it is the oldest match. Every chosen miss is the oldest slot that qualifies, and a BANK_READY choice really has a ready bank. The mask never names a bank without waiting slots, and it is never empty while slots wait. A bank with an open row is never reported ready. The exact estimate arithmetic is shown only by the bench's scenarios: the precharge-plus-T_RP sum, tie handling in the mask, flat bank numbering across ranks, the inclusive ready boundary, and the one-cycle registration timing.

// File: rtl/dram_pick_pkg.sv
package dram_pick_pkg;
    typedef enum logic [1:0] {
        PK_NONE  = 2'd0,
        PK_HIT   = 2'd1,
        PK_READY = 2'd2,
        PK_EARLY = 2'd3
    } pick_kind_e;
endpackage

// File: rtl/bank_act_est.sv
module bank_act_est #(
    parameter int NUM_BANKS = 16,
    parameter int TIME_W    = 32,
    parameter int T_RP      = 14,
    parameter int EST_W     = TIME_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS-1:0]          bank_open,
    input  logic [NUM_BANKS*TIME_W-1:0]   bank_act_ok,
    input  logic [NUM_BANKS*TIME_W-1:0]   bank_pre_ok,
    input  logic [TIME_W-1:0]             now,
    output logic [NUM_BANKS*EST_W-1:0]    est,
    output logic [NUM_BANKS-1:0]          ready
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [TIME_W-1:0] pre_v;
        logic [TIME_W-1:0] pre_from;
        logic [EST_W-1:0]  est_b;

        assign pre_v    = bank_pre_ok[b*TIME_W +: TIME_W];
        assign pre_from = (pre_v > now) ? pre_v : now;
        // open row: wait for the precharge to be allowed, then add its duration
        assign est_b    = bank_open[b] ? (EST_W'(pre_from) + EST_W'(T_RP))
                                       : EST_W'(bank_act_ok[b*TIME_W +: TIME_W]);
        assign est[b*EST_W +: EST_W] = est_b;
        assign ready[b] = (est_b <= EST_W'(now));

        assert_open_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
            bank_open[b] |-> !ready[b]);
    end
endmodule

// File: rtl/early_mask.sv
module early_mask #(
    parameter int NUM_BANKS = 16,
    parameter int EST_W     = 33
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS-1:0]       waiting,
    input  logic [NUM_BANKS*EST_W-1:0] est,
    output logic [NUM_BANKS-1:0]       mask
);
    logic [EST_W-1:0] run_min;

    // running minimum: a lower value restarts the mask, an equal one joins it
    always_comb begin
        run_min = '1;
        mask    = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (waiting[b]) begin
                if (est[b*EST_W +: EST_W] < run_min) begin
                    mask    = '0;
                    mask[b] = 1'b1;
                    run_min = est[b*EST_W +: EST_W];
                end else if (est[b*EST_W +: EST_W] == run_min) begin
                    mask[b] = 1'b1;
                end
            end
        end
    end

    assert_mask_only_waiting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask & ~waiting) == '0);
    assert_mask_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|waiting) |-> (|mask));
endmodule

// File: rtl/queue_scan.sv
module queue_scan
    import dram_pick_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int NUM_BANKS = 16,
    parameter int BANK_IW   = 4,
    parameter int ROW_W     = 16,
    parameter int IDX_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DEPTH-1:0]           ent_vld,
    input  logic [DEPTH*BANK_IW-1:0]   ent_bid,
    input  logic [DEPTH*ROW_W-1:0]     ent_row,
    input  logic [NUM_BANKS-1:0]       bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0] bank_row,
    input  logic [NUM_BANKS-1:0]       bank_ready,
    input  logic [NUM_BANKS-1:0]       soon_mask,
    output pick_kind_e                 nxt_kind,
    output logic [IDX_W-1:0]           nxt_idx
);
    logic [DEPTH-1:0] hit, cand, rdy_e, below_sel;
    logic [IDX_W-1:0] hit_idx, cand_idx, old_idx;
    logic             hit_any, cand_any, vld_any, cand_rdy;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [BANK_IW-1:0] bid;
        assign bid      = ent_bid[i*BANK_IW +: BANK_IW];
        assign hit[i]   = ent_vld[i] && bank_open[bid]
                          && (bank_row[bid*ROW_W +: ROW_W] == ent_row[i*ROW_W +: ROW_W]);
        assign rdy_e[i] = bank_ready[bid];
        assign cand[i]  = ent_vld[i] && (bank_ready[bid] || soon_mask[bid]);
    end

    // descending walk so the oldest qualifying slot is the one left standing
    always_comb begin
        hit_idx  = '0;
        hit_any  = 1'b0;
        cand_idx = '0;
        cand_any = 1'b0;
        cand_rdy = 1'b0;
        old_idx  = '0;
        vld_any  = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (cand[i]) begin
                cand_any = 1'b1;
                cand_idx = IDX_W'(i);
                cand_rdy = rdy_e[i];
            end
            if (ent_vld[i]) begin
                vld_any = 1'b1;
                old_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        unique casez ({hit_any, cand_any, vld_any})
            3'b1??: begin
                nxt_kind = PK_HIT;
                nxt_idx  = hit_idx;
            end
            3'b01?: begin
                nxt_kind = cand_rdy ? PK_READY : PK_EARLY;
                nxt_idx  = cand_idx;
            end
            3'b001: begin
                nxt_kind = PK_EARLY;
                nxt_idx  = old_idx;
            end
            default: begin
                nxt_kind = PK_NONE;
                nxt_idx  = '0;
            end
        endcase
    end

    assign below_sel = (DEPTH'(1) << nxt_idx) - DEPTH'(1);

    assert_pick_is_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_kind != PK_NONE) |-> ent_vld[nxt_idx]);
    assert_empty_is_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_vld == '0) |-> (nxt_kind == PK_NONE));
    assert_oldest_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (nxt_kind == PK_HIT && hit[nxt_idx] && (hit & below_sel) == '0));
    assert_oldest_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0 && cand != '0) |-> (cand[nxt_idx] && (cand & below_sel) == '0));
    assert_ready_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_kind == PK_READY) |-> rdy_e[nxt_idx]);
endmodule

// File: rtl/dram_row_picker.sv
module dram_row_picker
    import dram_pick_pkg::*;
#(
    parameter int DEPTH          = 16,
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int ROW_W          = 16,
    parameter int TIME_W         = 32,
    parameter int T_RP           = 14,
    localparam int NUM_BANKS     = NUM_RANKS * BANKS_PER_RANK,
    localparam int RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W        = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
    localparam int IDX_W         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0]              ent_vld,
    input  logic [DEPTH*RANK_W-1:0]       ent_rank,
    input  logic [DEPTH*BANK_W-1:0]       ent_bank,
    input  logic [DEPTH*ROW_W-1:0]        ent_row,
    input  logic [NUM_BANKS-1:0]          bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0]    bank_row,
    input  logic [NUM_BANKS*TIME_W-1:0]   bank_act_ok,
    input  logic [NUM_BANKS*TIME_W-1:0]   bank_pre_ok,
    input  logic [TIME_W-1:0]             now,
    output logic                          pick_valid,
    output logic [IDX_W-1:0]              pick_idx,
    output logic [1:0]                    pick_kind,
    output logic [NUM_BANKS-1:0]          early_mask
);
    localparam int BANK_IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int EST_W   = TIME_W + 1;

    initial assert (NUM_BANKS <= 64) else $error("bank count above 64 (R7)");

    logic [DEPTH*BANK_IW-1:0]   ent_bid;
    logic [NUM_BANKS-1:0]       waiting, bank_ready, soon_mask;
    logic [NUM_BANKS*EST_W-1:0] est;
    pick_kind_e                 nxt_kind, kind_q;
    logic [IDX_W-1:0]           nxt_idx, idx_q;
    logic [NUM_BANKS-1:0]       mask_q;

    // R7: flat bank number = rank * BANKS_PER_RANK + bank
    for (genvar i = 0; i < DEPTH; i++) begin : g_bid
        assign ent_bid[i*BANK_IW +: BANK_IW] =
            BANK_IW'(int'(ent_rank[i*RANK_W +: RANK_W]) * BANKS_PER_RANK
                     + int'(ent_bank[i*BANK_W +: BANK_W]));
    end

    always_comb begin
        waiting = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_vld[i]) waiting[ent_bid[i*BANK_IW +: BANK_IW]] = 1'b1;
        end
    end

    bank_act_est #(
        .NUM_BANKS(NUM_BANKS), .TIME_W(TIME_W), .T_RP(T_RP), .EST_W(EST_W)
    ) u_est (
        .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .bank_act_ok(bank_act_ok),
        .bank_pre_ok(bank_pre_ok), .now(now), .est(est), .ready(bank_ready)
    );

    early_mask #(.NUM_BANKS(NUM_BANKS), .EST_W(EST_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .waiting(waiting), .est(est), .mask(soon_mask)
    );

    queue_scan #(
        .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_IW(BANK_IW),
        .ROW_W(ROW_W), .IDX_W(IDX_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .ent_vld(ent_vld), .ent_bid(ent_bid),
        .ent_row(ent_row), .bank_open(bank_open), .bank_row(bank_row),
        .bank_ready(bank_ready), .soon_mask(soon_mask),
        .nxt_kind(nxt_kind), .nxt_idx(nxt_idx)
    );

    // state register: decision class
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) kind_q <= PK_NONE;
        else        kind_q <= nxt_kind;
    end

    // output register: chosen slot and mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mask_q <= '0;
        end else begin
            idx_q  <= nxt_idx;
            mask_q <= soon_mask;
        end
    end

    assign pick_valid = (kind_q != PK_NONE);
    assign pick_kind  = kind_q;
    assign pick_idx   = idx_q;
    assign early_mask = mask_q;

    assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == PK_NONE) |-> (idx_q == '0 && mask_q == '0));
endmodule

// File: tb/dram_row_picker_tb.sv
module dram_row_picker_tb;
    localparam int DEPTH = 4, NR = 2, BPR = 2, RW = 4, TW = 8, TRP = 3;

    typedef struct packed {
        logic [3:0]  vld;
        logic [3:0]  rank;
        logic [3:0]  bank;
        logic [15:0] row;
        logic [3:0]  open;
        logic [15:0] brow;
        logic [31:0] act;
        logic [31:0] pre;
        logic [7:0]  now;
        logic        ev;
        logic [1:0]  eidx;
        logic [1:0]  ekind;
        logic [3:0]  emask;
    } vec_t;

    // kind: 0 idle, 1 open-row hit, 2 bank ready, 3 soonest bank
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 4'h0, 4'h6, 16'h7325, 4'h3, 16'h0037, 32'h00000000, 32'h00000514, 8'h0A, 1'b1, 2'd2, 2'd1, 4'h2}, // R3
        '{4'hF, 4'h3, 4'h1, 16'h2111, 4'h0, 16'h0000, 32'h28050032, 32'h00000000, 8'h14, 1'b1, 2'd1, 2'd2, 4'h4}, // R5
        '{4'hE, 4'hA, 4'h6, 16'h1119, 4'h1, 16'h0009, 32'h1E281E00, 32'h00000000, 8'h0A, 1'b1, 2'd1, 2'd3, 4'hA}, // R6 R2
        '{4'hF, 4'h4, 4'h2, 16'h3042, 4'h1, 16'h0001, 32'h000E0D00, 32'h00000002, 8'h0A, 1'b1, 2'd0, 2'd3, 4'h3}, // R4
        '{4'h3, 4'h0, 4'h1, 16'h0000, 4'h0, 16'h0000, 32'h00001914, 32'h00000000, 8'h14, 1'b1, 2'd1, 2'd2, 4'h1}, // R5 edge
        '{4'h0, 4'h0, 4'h6, 16'h7325, 4'h3, 16'h0037, 32'h00000000, 32'h00000514, 8'h0A, 1'b0, 2'd0, 2'd0, 4'h0}, // R2
        '{4'h1, 4'h1, 4'h1, 16'h0006, 4'hA, 16'h6090, 32'h00000000, 32'h00000000, 8'h05, 1'b1, 2'd0, 2'd1, 4'h8}  // R7
    };
    localparam string VREQ [NV] = '{"R3", "R5", "R6", "R4", "R5", "R2", "R7"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ent_vld, ent_rank, ent_bank, bank_open;
    logic [15:0] ent_row, bank_row;
    logic [31:0] bank_act_ok, bank_pre_ok;
    logic [7:0]  now;
    logic        pick_valid;
    logic [1:0]  pick_idx, pick_kind;
    logic [3:0]  early_mask;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    dram_row_picker #(
        .DEPTH(DEPTH), .NUM_RANKS(NR), .BANKS_PER_RANK(BPR),
        .ROW_W(RW), .TIME_W(TW), .T_RP(TRP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ent_vld(ent_vld), .ent_rank(ent_rank),
        .ent_bank(ent_bank), .ent_row(ent_row), .bank_open(bank_open),
        .bank_row(bank_row), .bank_act_ok(bank_act_ok), .bank_pre_ok(bank_pre_ok),
        .now(now), .pick_valid(pick_valid), .pick_idx(pick_idx),
        .pick_kind(pick_kind), .early_mask(early_mask)
    );

    task automatic drive(input vec_t x);
        ent_vld = x.vld; ent_rank = x.rank; ent_bank = x.bank; ent_row = x.row;
        bank_open = x.open; bank_row = x.brow; bank_act_ok = x.act;
        bank_pre_ok = x.pre; now = x.now;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input vec_t x);
        chk(req, "valid", int'(pick_valid), int'(x.ev));
        chk(req, "idx",   int'(pick_idx),   int'(x.eidx));
        chk(req, "kind",  int'(pick_kind),  int'(x.ekind));
        chk(req, "mask",  int'(early_mask), int'(x.emask));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        drive(VECS[0]);
        // R1: reset holds outputs at idle despite live inputs
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "valid", int'(pick_valid), 0);
        chk("R1", "kind",  int'(pick_kind), 0);
        chk("R1", "mask",  int'(early_mask), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            drive(VECS[v]);
            @(posedge clk);
            #1;
            chk_out(VREQ[v], VECS[v]);
        end

        // R8: one-cycle registration, held between edges
        @(negedge clk);
        drive(VECS[0]);
        @(posedge clk);
        #1;
        chk("R8", "idx after edge", int'(pick_idx), 2);
        @(negedge clk);
        drive(VECS[5]);
        #1;
        chk("R8", "valid held before edge", int'(pick_valid), 1);
        chk("R8", "kind held before edge", int'(pick_kind), 1);
        @(posedge clk);
        #1;
        chk("R8", "valid after edge", int'(pick_valid), 0);
        chk("R8", "mask after edge", int'(early_mask), 0);

        // R1: re-entering reset clears a live choice
        @(negedge clk);
        drive(VECS[1]);
        @(posedge clk);
        #1;
        chk("R5", "ready pick", int'(pick_kind), 2);
        rst_n = 1'b0;
        #1;
        chk("R1", "async clear valid", int'(pick_valid), 0);
        chk("R1", "async clear idx", int'(pick_idx), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule